// File: doc/BRIEF.md
# UART Hardware Flow Control

This block produces the request-to-send line and a transmit-permit signal for a UART, using the standard RTS/CTS handshake. It sits between the receive buffer, the transmit serializer and the two handshake pins. The RTS output can come from one of three sources. When disabled, it rests at its idle high level. In automatic mode it is derived from how full the receive buffer is, compared against a programmable threshold, and the result can be inverted. In manual mode it follows a value bit written by software.

On the transmit side, the CTS pin is first brought into the clock domain through a synchronizer. When the CTS function is enabled and the synchronized pin equals a selectable halt level, the transmit permit is withdrawn. The permit changes only between characters. While the serializer reports that a frame is in progress, the permit keeps its value, so a started character always completes. Both outputs are registered, and the reset is synchronous and active high.

Top module: `uart_flow_ctl`

## Requirements
- R1: While reset is high and on the first cycle after it, rts_out is 1 and tx_permit is 0.
- R2: With rts_en low, rts_out is 1 one cycle later, whatever the buffer level, mode, invert and manual value are.
- R3: With rts_en high, rts_manual low and rts_invert low, rts_out one cycle later is 1 when rx_level >= rts_thresh and 0 otherwise.
- R4: In automatic mode with rts_invert high, rts_out one cycle later is 1 when rx_level < rts_thresh and 0 when rx_level >= rts_thresh.
- R5: With rts_en and rts_manual high, rts_out one cycle later equals rts_manual_val, and rx_level, rts_thresh and rts_invert have no effect.
- R6: With cts_en low and tx_frame_active low, tx_permit is 1 one cycle later, whatever cts_pin is.
- R7: With cts_en high and tx_frame_active low, a change on cts_pin reaches tx_permit after exactly three rising edges. It passes through two synchronizer flops and then the permit register.
- R8: cts_halt_level selects the halting polarity. With it at 0, a cts_pin of 0 halts (tx_permit 0) and 1 permits. With it at 1, a cts_pin of 1 halts and 0 permits.
- R9: While tx_frame_active is high, tx_permit keeps its value. A pending change applies on the first cycle after tx_frame_active has gone low.
- R10: The threshold compare includes equality. rx_level = rts_thresh - 1 gives the below-threshold level, rx_level = rts_thresh gives the at-threshold level, and rts_thresh = 0 with rx_level = 0 counts as reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_level | input | CNT_W | Number of bytes held in the receive buffer |
| rts_en | input | 1 | Enables RTS generation |
| rts_manual | input | 1 | 1 selects the manual RTS source, 0 selects the automatic source |
| rts_invert | input | 1 | Inverts the automatic RTS level |
| rts_thresh | input | CNT_W | Buffer level at which automatic RTS changes |
| rts_manual_val | input | 1 | RTS level driven in manual mode |
| cts_en | input | 1 | Enables CTS halting |
| cts_halt_level | input | 1 | CTS pin level that halts transmission |
| cts_pin | input | 1 | Asynchronous CTS input pin |
| tx_frame_active | input | 1 | High while the serializer is sending a character |
| rts_out | output | 1 | RTS pin level (registered) |
| tx_permit | output | 1 | Serializer may start a new character (registered) |

## Verification
The receive-side threshold crossing and the transmit-side CTS halt are independent paths, so both registered outputs can change on the same edge. The bench provokes this by moving rx_level across rts_thresh on the same negative edge that cts_pin moves to the halt level. The scoreboard then expects rts_out to flip one edge later and tx_permit to fall three edges later, with each output checked separately at its own due cycle. A related collision, a CTS halt that arrives while a frame is active, is judged by checking that tx_permit holds through the frame and falls only once tx_frame_active has dropped.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

  typedef enum logic [1:0] {
    RTS_SRC_IDLE   = 2'd0,
    RTS_SRC_AUTO   = 2'd1,
    RTS_SRC_MANUAL = 2'd2
  } rts_src_e;

  function automatic rts_src_e pick_rts_src(input logic en, input logic manual);
    if (!en)
      return RTS_SRC_IDLE;
    else if (manual)
      return RTS_SRC_MANUAL;
    else
      return RTS_SRC_AUTO;
  endfunction

endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  // The first stage samples the asynchronous pin; each later stage resamples the one before it.
  always_ff @(posedge clk) begin
    if (rst)
      chain_q[0] <= RST_VAL;
    else
      chain_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        chain_q[g] <= RST_VAL;
      else
        chain_q[g] <= chain_q[g-1];
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/flow_rts_gen.sv
module flow_rts_gen
  import uart_flow_pkg::*;
#(
  parameter int   CNT_W    = 5,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] thresh,
  input  logic             en,
  input  logic             manual,
  input  logic             invert,
  input  logic             man_val,
  output logic             rts_q
);

  rts_src_e src;
  logic     reached;
  logic     rts_nxt;

  assign src     = pick_rts_src(en, manual);
  assign reached = (level >= thresh);

  always_comb begin
    case (src)
      RTS_SRC_AUTO:   rts_nxt = reached ^ invert;
      RTS_SRC_MANUAL: rts_nxt = man_val;
      default:        rts_nxt = IDLE_LVL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rts_q <= IDLE_LVL;
    else
      rts_q <= rts_nxt;
  end

endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic cts_en,
  input  logic halt_lvl,
  input  logic cts_s,
  input  logic frame_busy,
  output logic permit_q
);

  logic halt_now;

  assign halt_now = cts_en && (cts_s == halt_lvl);

  // The permit is re-evaluated only between characters.
  always_ff @(posedge clk) begin
    if (rst)
      permit_q <= 1'b0;
    else if (!frame_busy)
      permit_q <= !halt_now;
  end

endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int   CNT_W       = 5,
  parameter int   SYNC_STAGES = 2,
  parameter logic RTS_IDLE    = 1'b1,
  parameter logic CTS_RST     = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rts_en,
  input  logic             rts_manual,
  input  logic             rts_invert,
  input  logic [CNT_W-1:0] rts_thresh,
  input  logic             rts_manual_val,
  input  logic             cts_en,
  input  logic             cts_halt_level,
  input  logic             cts_pin,
  input  logic             tx_frame_active,
  output logic             rts_out,
  output logic             tx_permit
);

  logic cts_sync;

  flow_rts_gen #(
    .CNT_W   (CNT_W),
    .IDLE_LVL(RTS_IDLE)
  ) u_rts (
    .clk    (clk),
    .rst    (rst),
    .level  (rx_level),
    .thresh (rts_thresh),
    .en     (rts_en),
    .manual (rts_manual),
    .invert (rts_invert),
    .man_val(rts_manual_val),
    .rts_q  (rts_out)
  );

  flow_cts_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTS_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (cts_pin),
    .dout(cts_sync)
  );

  flow_tx_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .cts_en    (cts_en),
    .halt_lvl  (cts_halt_level),
    .cts_s     (cts_sync),
    .frame_busy(tx_frame_active),
    .permit_q  (tx_permit)
  );

endmodule

// File: rtl/uart_flow_ctl_chk.sv
module uart_flow_ctl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] rx_level,
  input logic             rts_en,
  input logic             rts_manual,
  input logic             rts_invert,
  input logic [CNT_W-1:0] rts_thresh,
  input logic             rts_manual_val,
  input logic             cts_en,
  input logic             cts_halt_level,
  input logic             cts_sync,
  input logic             tx_frame_active,
  input logic             rts_out,
  input logic             tx_permit
);

  // R2
  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !rts_en |=> rts_out);

  // R3, R4, R10
  a_r3_auto_level: assert property (@(posedge clk) disable iff (rst)
    (rts_en && !rts_manual) |=>
      rts_out == (($past(rx_level) >= $past(rts_thresh)) ^ $past(rts_invert)));

  // R5
  a_r5_manual_follow: assert property (@(posedge clk) disable iff (rst)
    (rts_en && rts_manual) |=> rts_out == $past(rts_manual_val));

  // R6
  a_r6_cts_off_permits: assert property (@(posedge clk) disable iff (rst)
    (!cts_en && !tx_frame_active) |=> tx_permit);

  // R7, R8
  a_r7_halt_on_match: assert property (@(posedge clk) disable iff (rst)
    (cts_en && !tx_frame_active && cts_sync == cts_halt_level) |=> !tx_permit);

  // R9
  a_r9_hold_in_frame: assert property (@(posedge clk) disable iff (rst)
    tx_frame_active |=> $stable(tx_permit));

endmodule

bind uart_flow_ctl uart_flow_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .rx_level       (rx_level),
  .rts_en         (rts_en),
  .rts_manual     (rts_manual),
  .rts_invert     (rts_invert),
  .rts_thresh     (rts_thresh),
  .rts_manual_val (rts_manual_val),
  .cts_en         (cts_en),
  .cts_halt_level (cts_halt_level),
  .cts_sync       (cts_sync),
  .tx_frame_active(tx_frame_active),
  .rts_out        (rts_out),
  .tx_permit      (tx_permit)
);

// File: tb/tb_uart_flow_ctl.sv
module tb_uart_flow_ctl;

  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] rx_level = '0;
  logic             rts_en = 1'b0;
  logic             rts_manual = 1'b0;
  logic             rts_invert = 1'b0;
  logic [CNT_W-1:0] rts_thresh = '0;
  logic             rts_manual_val = 1'b0;
  logic             cts_en = 1'b0;
  logic             cts_halt_level = 1'b0;
  logic             cts_pin = 1'b1;
  logic             tx_frame_active = 1'b0;
  logic             rts_out;
  logic             tx_permit;

  uart_flow_ctl #(.CNT_W(CNT_W)) dut (
    .clk            (clk),
    .rst            (rst),
    .rx_level       (rx_level),
    .rts_en         (rts_en),
    .rts_manual     (rts_manual),
    .rts_invert     (rts_invert),
    .rts_thresh     (rts_thresh),
    .rts_manual_val (rts_manual_val),
    .cts_en         (cts_en),
    .cts_halt_level (cts_halt_level),
    .cts_pin        (cts_pin),
    .tx_frame_active(tx_frame_active),
    .rts_out        (rts_out),
    .tx_permit      (tx_permit)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    due;
    bit    chk_rts;
    bit    exp_rts;
    bit    chk_perm;
    bit    exp_perm;
    string req;
  } exp_item_t;

  exp_item_t sb_q[$];
  int  cyc = 0;
  int  n_tests = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  // Monitor: one step after each rising edge, compare the items due now.
  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      exp_item_t it;
      it = sb_q.pop_front();
      if (it.chk_rts) begin
        n_tests++;
        if (rts_out !== it.exp_rts) begin
          n_fail++;
          $display("FAIL %s rts_out actual=%b expected=%b (cycle %0d)",
                   it.req, rts_out, it.exp_rts, cyc);
        end
      end
      if (it.chk_perm) begin
        n_tests++;
        if (tx_permit !== it.exp_perm) begin
          n_fail++;
          $display("FAIL %s tx_permit actual=%b expected=%b (cycle %0d)",
                   it.req, tx_permit, it.exp_perm, cyc);
        end
      end
    end
  end

  // Driver side: queue an expectation k rising edges from now.
  task automatic expect_at(input int k, input bit cr, input bit er,
                           input bit cp, input bit ep, input string req);
    exp_item_t it;
    it.due = cyc + k; it.chk_rts = cr; it.exp_rts = er;
    it.chk_perm = cp; it.exp_perm = ep; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    expect_at(1, 1, 1'b1, 1, 1'b0, "R1");
    step(1);
    rst = 1'b0;
    expect_at(1, 1, 1'b1, 0, 1'b0, "R1");
    step(1);

    // R2 disabled RTS idles high, R6 permit with CTS off
    rx_level = 5'd20; rts_thresh = 5'd4; rts_invert = 1'b1;
    expect_at(1, 1, 1'b1, 1, 1'b1, "R2/R6");
    step(2);

    // R3 automatic, no inversion, R10 boundary
    rts_en = 1'b1; rts_invert = 1'b0; rts_thresh = 5'd8;
    rx_level = 5'd7;  expect_at(1, 1, 1'b0, 0, 1'b0, "R3/R10 below"); step(1);
    rx_level = 5'd8;  expect_at(1, 1, 1'b1, 0, 1'b0, "R3/R10 equal"); step(1);
    rx_level = 5'd20; expect_at(1, 1, 1'b1, 0, 1'b0, "R3 above");     step(1);
    rx_level = 5'd0;  expect_at(1, 1, 1'b0, 0, 1'b0, "R3 empty");     step(1);
    rts_thresh = 5'd0; expect_at(1, 1, 1'b1, 0, 1'b0, "R10 zero thresh"); step(1);

    // R4 inverted automatic
    rts_invert = 1'b1; rts_thresh = 5'd8;
    rx_level = 5'd7; expect_at(1, 1, 1'b1, 0, 1'b0, "R4 below"); step(1);
    rx_level = 5'd8; expect_at(1, 1, 1'b0, 0, 1'b0, "R4 equal"); step(1);

    // R5 manual ignores level, threshold and invert
    rts_manual = 1'b1; rts_manual_val = 1'b0; rx_level = 5'd31; rts_thresh = 5'd1;
    expect_at(1, 1, 1'b0, 0, 1'b0, "R5 val0"); step(1);
    rts_manual_val = 1'b1;
    expect_at(1, 1, 1'b1, 0, 1'b0, "R5 val1"); step(1);
    rts_manual_val = 1'b0; rts_invert = 1'b0; rx_level = 5'd0;
    expect_at(1, 1, 1'b0, 0, 1'b0, "R5 val0 low level"); step(1);

    // R2 from manual low
    rts_en = 1'b0;
    expect_at(1, 1, 1'b1, 0, 1'b0, "R2 from manual"); step(1);

    // R6 pin at the would-be halt level is ignored when CTS is off
    cts_halt_level = 1'b0; cts_pin = 1'b0;
    expect_at(3, 0, 1'b0, 1, 1'b1, "R6 pin ignored"); step(4);

    // R7 latency with halt level 0
    cts_pin = 1'b1; cts_en = 1'b1;
    expect_at(3, 0, 1'b0, 1, 1'b1, "R8 lvl0 pin1 permits"); step(4);
    cts_pin = 1'b0;
    expect_at(2, 0, 1'b0, 1, 1'b1, "R7 not yet");
    expect_at(3, 0, 1'b0, 1, 1'b0, "R7 halt at third edge");
    step(4);

    // R8 halt level 1
    cts_halt_level = 1'b1;
    expect_at(1, 0, 1'b0, 1, 1'b1, "R8 lvl1 pin0 permits"); step(2);
    cts_pin = 1'b1;
    expect_at(3, 0, 1'b0, 1, 1'b0, "R8 lvl1 pin1 halts"); step(4);

    // R9 hold during a frame
    cts_pin = 1'b0;
    expect_at(3, 0, 1'b0, 1, 1'b1, "R9 setup"); step(4);
    tx_frame_active = 1'b1; cts_pin = 1'b1;
    expect_at(3, 0, 1'b0, 1, 1'b1, "R9 hold high");
    expect_at(4, 0, 1'b0, 1, 1'b1, "R9 hold high");
    step(4);
    tx_frame_active = 1'b0;
    expect_at(1, 0, 1'b0, 1, 1'b0, "R9 apply after frame"); step(2);
    tx_frame_active = 1'b1; cts_pin = 1'b0;
    expect_at(4, 0, 1'b0, 1, 1'b0, "R9 hold low"); step(4);
    tx_frame_active = 1'b0;
    expect_at(1, 0, 1'b0, 1, 1'b1, "R9 release after frame"); step(2);

    // Same-cycle: threshold crossing and CTS halt together (R3, R7)
    rts_en = 1'b1; rts_manual = 1'b0; rts_invert = 1'b0; rts_thresh = 5'd8; rx_level = 5'd7;
    expect_at(1, 1, 1'b0, 1, 1'b1, "R3 pre-collision"); step(2);
    rx_level = 5'd8; cts_pin = 1'b1;
    expect_at(1, 1, 1'b1, 1, 1'b1, "R3 collision rts");
    expect_at(3, 1, 1'b1, 1, 1'b0, "R7 collision halt");
    step(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule